// File: doc/BRIEF.md
# ALU Result Selector with Replicated Select Registers

This block picks one of 64 candidate results produced by the arithmetic units of an ALU and presents it as the stage result. Every candidate is a 35-bit entry carrying a 32-bit value, a carry flag, a zero flag and an override bit that tells later logic to force the zero flag. A 6-bit select code arrives one cycle before it is needed, qualified by a valid strobe. It is captured in flip-flops so that the steering lines are already stable when the cycle that uses them begins.

Four flip-flop copies of the select code are loaded on the same edge from the same code. Each copy steers only one slice of the output word. The load on any single select line is therefore about a quarter of what one shared set of select lines would carry. The candidates themselves are not registered: the output follows the currently selected candidate within the cycle. A code presented without the strobe is ignored, and the previous selection stays in force.

Top module: `alu_result_sel`

## Requirements
- R1: While reset is high at a clock edge, every select copy is cleared to code 0. After reset the output equals candidate 0.
- R2: A code presented with the valid strobe high at a rising edge steers the output from that edge on. It has no effect on the output before that edge.
- R3: A code presented with the valid strobe low is ignored, and the output keeps following the previously selected candidate.
- R4: The output follows changes in the data of the selected candidate within the same cycle, with no register in the data path.
- R5: Changes to candidates that are not selected leave the output unchanged.
- R6: The four select copies always hold the same code, and every output slice comes from the same candidate. The slices are bits 0–8, 9–17, 18–26 and 27–34.
- R7: Candidate k occupies bits [35k+34:35k] of the flat candidate bus. Within an entry, bits 31:0 hold the value, bit 32 the carry, bit 33 the zero flag and bit 34 the override. The output uses the same layout.
- R8: Valid codes on consecutive edges each take effect one edge after they are presented, including the extreme codes 0 and 63.
- R9: When reset and the valid strobe are both high at the same edge, reset wins and the selection becomes code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_code_i | input | 6 | Select code for the next cycle |
| sel_vld_i | input | 1 | Strobe qualifying sel_code_i |
| cand_i | input | 2240 | 64 candidate entries of 35 bits, packed |
| result_o | output | 35 | Selected candidate entry |

## Verification
Two events are made to land in the same cycle: the loading of a new select code, and a data change on the candidate that code names. The bench drives both on one falling edge. It then expects the new candidate's fresh data on the output right after the following rising edge. The old selection's data, or the new candidate's stale data, would both be wrong. A second collision asserts reset together with a valid code, and the bench expects candidate 0. In both cases the expected entry comes from the bench's own copy of the candidate bus and its own record of which code should be in force.

// File: rtl/arsel_pkg.sv
package arsel_pkg;

    localparam int NUM_IN  = 64;
    localparam int RES_W   = 32;
    localparam int N_COPY  = 4;
    localparam int FLAG_W  = 3;
    localparam int ENTRY_W = RES_W + FLAG_W;
    localparam int SEL_W   = $clog2(NUM_IN);

    // One candidate entry: override, zero, carry, value (msb first)
    typedef struct packed {
        logic             ovr;
        logic             zf;
        logic             cf;
        logic [RES_W-1:0] val;
    } entry_t;

    // Lowest output bit steered by select copy k when w bits are split n ways.
    // The first (w mod n) slices get one extra bit.
    function automatic int slice_lo(input int k, input int w, input int n);
        int base;
        int extra;
        base  = w / n;
        extra = w % n;
        return k * base + ((k < extra) ? k : extra);
    endfunction

endpackage

// File: rtl/arsel_sel_copy.sv
module arsel_sel_copy #(
    parameter int SEL_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [SEL_W-1:0] code_i,
    output logic [SEL_W-1:0] code_q
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= '0;
        end else if (load_i) begin
            code_q <= code_i;
        end
    end

endmodule

// File: rtl/arsel_slice_mux.sv
module arsel_slice_mux #(
    parameter int NUM_IN  = 64,
    parameter int SEL_W   = 6,
    parameter int ENTRY_W = 35,
    parameter int LO      = 0,
    parameter int HI      = 8
) (
    input  logic [SEL_W-1:0]          sel_i,
    input  logic [NUM_IN*ENTRY_W-1:0] cand_i,
    output logic [HI-LO:0]            slice_o
);

    localparam int SW = HI - LO + 1;

    always_comb begin
        slice_o = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (sel_i == SEL_W'(i)) begin
                slice_o = cand_i[i*ENTRY_W + LO +: SW];
            end
        end
    end

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
    import arsel_pkg::*;
#(
    parameter int NUM_IN_P  = arsel_pkg::NUM_IN,
    parameter int ENTRY_W_P = arsel_pkg::ENTRY_W,
    parameter int N_COPY_P  = arsel_pkg::N_COPY
) (
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic [$clog2(NUM_IN_P)-1:0]       sel_code_i,
    input  logic                              sel_vld_i,
    input  logic [NUM_IN_P*ENTRY_W_P-1:0]     cand_i,
    output logic [ENTRY_W_P-1:0]              result_o
);

    localparam int SW_L = $clog2(NUM_IN_P);

    // All select copies, copy k at [k*SW_L +: SW_L]
    logic [N_COPY_P*SW_L-1:0] sel_q;

    for (genvar k = 0; k < N_COPY_P; k++) begin : g_copy
        localparam int LO = slice_lo(k, ENTRY_W_P, N_COPY_P);
        localparam int HI = slice_lo(k + 1, ENTRY_W_P, N_COPY_P) - 1;

        arsel_sel_copy #(
            .SEL_W (SW_L)
        ) u_sel (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .load_i (sel_vld_i),
            .code_i (sel_code_i),
            .code_q (sel_q[k*SW_L +: SW_L])
        );

        arsel_slice_mux #(
            .NUM_IN  (NUM_IN_P),
            .SEL_W   (SW_L),
            .ENTRY_W (ENTRY_W_P),
            .LO      (LO),
            .HI      (HI)
        ) u_mux (
            .sel_i   (sel_q[k*SW_L +: SW_L]),
            .cand_i  (cand_i),
            .slice_o (result_o[HI:LO])
        );
    end

endmodule

// File: rtl/arsel_chk.sv
module arsel_chk #(
    parameter int NUM_IN  = 64,
    parameter int ENTRY_W = 35,
    parameter int N_COPY  = 4,
    parameter int SEL_W   = 6
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [SEL_W-1:0]          sel_code_i,
    input  logic                      sel_vld_i,
    input  logic [NUM_IN*ENTRY_W-1:0] cand_i,
    input  logic [ENTRY_W-1:0]        result_o,
    input  logic [N_COPY*SEL_W-1:0]   copies
);

    // Shadow of the selection, kept from the ports only
    logic [SEL_W-1:0] shadow_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shadow_q <= '0;
        end else if (sel_vld_i) begin
            shadow_q <= sel_code_i;
        end
    end

    logic copies_agree;
    always_comb begin
        copies_agree = 1'b1;
        for (int k = 1; k < N_COPY; k++) begin
            if (copies[k*SEL_W +: SEL_W] != copies[SEL_W-1:0]) begin
                copies_agree = 1'b0;
            end
        end
    end

    logic [ENTRY_W-1:0] ref_entry;
    always_comb begin
        ref_entry = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (shadow_q == SEL_W'(i)) begin
                ref_entry = cand_i[i*ENTRY_W +: ENTRY_W];
            end
        end
    end

    // R1 / R9: reset clears every copy, whatever the strobe does
    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (copies == '0));

    // R2 / R8: a strobed code lands in the copies one edge later
    a_r2_load_next: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_vld_i |=> (copies[SEL_W-1:0] == $past(sel_code_i)));

    // R3: no strobe, no change of selection
    a_r3_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_vld_i |=> $stable(copies));

    // R6: replicated copies never diverge
    a_r6_copies_agree: assert property (@(posedge clk_i) disable iff (rst_i)
        copies_agree);

    // R4 / R5 / R6: output matches a single-select reference mux
    a_r4_ref_match: assert property (@(posedge clk_i) disable iff (rst_i)
        result_o == ref_entry);

endmodule

bind alu_result_sel arsel_chk #(
    .NUM_IN  (NUM_IN_P),
    .ENTRY_W (ENTRY_W_P),
    .N_COPY  (N_COPY_P),
    .SEL_W   ($clog2(NUM_IN_P))
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_code_i (sel_code_i),
    .sel_vld_i  (sel_vld_i),
    .cand_i     (cand_i),
    .result_o   (result_o),
    .copies     (sel_q)
);

// File: tb/alu_result_sel_tb.sv
`timescale 1ns/1ps
module alu_result_sel_tb;
    import arsel_pkg::*;

    localparam int EW = ENTRY_W;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [SEL_W-1:0]        code = '0;
    logic                    vld = 1'b0;
    logic [NUM_IN*EW-1:0]    cand = '0;
    logic [EW-1:0]           result;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_sel = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [EW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    alu_result_sel u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .sel_code_i (code),
        .sel_vld_i  (vld),
        .cand_i     (cand),
        .result_o   (result)
    );

    function automatic logic [EW-1:0] mk(input int i, input logic [31:0] seed);
        logic [31:0] v;
        v = 32'(i) * 32'h0101_0101 ^ seed;
        return {i[0], i[1], i[2], v};
    endfunction

    function automatic logic [EW-1:0] entry(input int i);
        return cand[i*EW +: EW];
    endfunction

    task automatic fill(input logic [31:0] seed);
        for (int i = 0; i < NUM_IN; i++) cand[i*EW +: EW] = mk(i, seed);
    endtask

    // Queue an expectation of the entry that should currently be selected
    task automatic expect_sel(input string tag);
        item_t it;
        it.exp = entry(exp_sel);
        it.tag = tag;
        sb_q.push_back(it);
        #0.1;
    endtask

    // Drive a code on the falling edge, pass the rising edge, then expect
    task automatic step(input int c, input logic v, input logic r, input string tag);
        @(negedge clk);
        code = SEL_W'(c);
        vld  = v;
        rst  = r;
        @(posedge clk);
        if (r) exp_sel = 0;
        else if (v) exp_sel = c;
        #1;
        expect_sel(tag);
    endtask

    // Monitor: pops expectations and compares with the output
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            n_tests++;
            if (result !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, result, it.exp);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        entry_t fe;
        fill(32'hA5A5_0000);
        // R9: reset together with a strobed code
        step(5, 1'b1, 1'b1, "R9 reset beats valid");
        step(5, 1'b0, 1'b1, "R1 reset state");
        step(5, 1'b0, 1'b0, "R1 candidate 0 after reset");

        // R2: latency; before the edge the old selection holds
        @(negedge clk);
        code = 6'd7; vld = 1'b1;
        #1;
        expect_sel("R2 no effect before edge");
        @(posedge clk); exp_sel = 7; #1;
        expect_sel("R2 takes effect at edge");

        // R3: code without strobe is ignored
        step(9, 1'b0, 1'b0, "R3 unstrobed code ignored");
        step(40, 1'b0, 1'b0, "R3 still ignored");

        // R4: selected data change shows within the cycle
        @(negedge clk);
        cand[7*EW +: EW] = mk(7, 32'h1234_5678);
        #1;
        expect_sel("R4 data follows same cycle");

        // R5: non-selected candidate changes have no effect
        @(negedge clk);
        cand[9*EW +: EW]  = mk(9, 32'hFFFF_FFFF);
        cand[40*EW +: EW] = ~entry(40);
        #1;
        expect_sel("R5 other candidates ignored");

        // R8: back-to-back extremes
        step(0, 1'b1, 1'b0, "R8 code 0");
        step(63, 1'b1, 1'b0, "R8 code 63");
        step(1, 1'b1, 1'b0, "R8 code 1");
        step(62, 1'b1, 1'b0, "R8 code 62");

        // R7: field layout on the output
        @(negedge clk);
        fe.ovr = 1'b1; fe.zf = 1'b0; fe.cf = 1'b1; fe.val = 32'hDEAD_BEEF;
        cand[62*EW +: EW] = fe;
        #1;
        n_tests++;
        if (result[34] !== 1'b1 || result[33] !== 1'b0 || result[32] !== 1'b1
            || result[31:0] !== 32'hDEAD_BEEF) begin
            n_fail++;
            $display("FAIL R7 field layout: got %h expected %h", result, fe);
        end

        // R6: every slice from one candidate; slices patterned per candidate
        fill(32'h5A3C_96E1);
        for (int i = 0; i < NUM_IN; i++) begin
            step(i, 1'b1, 1'b0, "R6 all slices one candidate");
        end
        for (int i = NUM_IN - 1; i >= 0; i -= 7) begin
            step(i, 1'b1, 1'b0, "R2 descending codes");
        end

        // Collision: new code and fresh data for that candidate in one cycle
        @(negedge clk);
        code = 6'd20; vld = 1'b1;
        cand[20*EW +: EW] = mk(20, 32'h0BAD_F00D);
        @(posedge clk); exp_sel = 20; #1;
        expect_sel("R4 load and data change together");

        // Mid-run reset with a strobed code
        step(30, 1'b1, 1'b1, "R9 mid-run reset");
        step(30, 1'b0, 1'b0, "R1 held after reset");
        step(30, 1'b1, 1'b0, "R2 load after reset");

        @(negedge clk);
        vld = 1'b0;
        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule